// File: doc/BRIEF.md
# Dual-CAS DRAM control decoder

This block holds the control logic of a 256K x 16 asynchronous DRAM. The strobes are sampled on a fast simulation clock. Its inputs are one active-low row strobe, one active-low column strobe for each byte lane, an active-low write enable, an active-low output enable and a 9-bit multiplexed address bus. The falling edge of the row strobe latches the row half of the cell address. The falling edge of the merged column strobe latches the column half.

The two lane column strobes merge into one internal column strobe. It becomes active when the first lane strobe falls and stays active until the last lane strobe has risen. Each lane strobe still gates the output enable and the write strobe of its own byte. The block drives those per-byte enables, and it reports every refreshed row together with the kind of the current cycle. A column strobe held low when the row strobe falls starts a refresh. In that refresh an internal 9-bit counter supplies the row, and no data moves.

The storage array is a small behavioural memory that keeps only the low bits of row and column. The data pins are plain DRAM-style pins, not a handshaked stream, so there is no back-pressure. A row strobe pulse that is too short, or a precharge that is too short, raises a sticky error flag.

Top module: `dram_dual_cas_ctl`

## Requirements
- R1: After reset, dq_oe, wr_strobe, rfsh_pulse and timing_err are 0 and cyc_kind is 0. The first counter refresh after reset uses row 0.
- R2: The row is latched on the clock where ras_n is first sampled low. One clock later, rfsh_pulse is 1 for a single clock. For a non-refresh cycle, rfsh_row then equals the address sampled with that fall.
- R3: The column is latched when the first lane column strobe falls. A second lane strobe falling later in the same cycle does not latch the column again. The lane that falls later joins the access with the column that was already latched.
- R4: dq_oe[i] is 1 one clock after lane i's column strobe, oe_n and ras_n are all sampled low with we_n high, so a read starts at whichever of column strobe and output enable falls later. dq_out for that lane then carries the stored byte. Lane 0 is bits 7:0 (lcas_n) and lane 1 is bits 15:8 (ucas_n).
- R5: A write to lane i happens on the clock where lane i's column strobe and we_n are both low and one of them has just fallen. dq_in is captured at that clock, and wr_strobe[i] is 1 for one clock after it.
- R6: A lane whose column strobe is high has dq_oe 0 and dq_out byte 0. Its stored byte is not written, even while the other lane reads or writes.
- R7: If the merged column strobe is low when ras_n falls, the cycle is a counter refresh. rfsh_row is the counter value and the address bus is ignored. No dq_oe or wr_strobe is raised during the cycle. The counter then increments and wraps from 511 to 0.
- R8: cyc_kind encodes 1 for a row-only cycle, 2 for a read, 3 for a write (a write wins over a read in the same cycle) and 4 for a counter refresh. It holds its value until the next ras_n fall.
- R9: timing_err becomes 1 and stays 1 until reset in two cases: ras_n is sampled low for fewer than T_RAS_MIN (4) clocks before rising, or it is sampled high for fewer than T_RP_MIN (3) clocks before falling.
- R10: The array keeps the low MEM_ROW_BITS (3) row bits and the low MEM_COL_BITS (3) column bits. Data written at one row and column reads back from the same row and column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-byte column strobe, active low |
| ucas_n | input | 1 | Upper-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row/column address |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data, zero in disabled lanes |
| dq_oe | output | 2 | Per-lane output enable (1 = driven) |
| wr_strobe | output | 2 | Per-lane write pulse |
| cyc_kind | output | 3 | Kind of the current or last cycle |
| rfsh_pulse | output | 1 | One-clock pulse when a row is refreshed |
| rfsh_row | output | 9 | Row refreshed with rfsh_pulse |
| timing_err | output | 1 | Sticky minimum-timing violation flag |

## Verification
The assertions take for granted that all strobes and data are synchronous to clk and stay steady between edges. They also assume that a column strobe never falls on the same sample as the row strobe. The stimulus changes every input on the falling clock edge. It holds the row strobe low for at least four samples and high for at least three, except in the two tests that break the timing on purpose. Before a refresh cycle it drops a lane column strobe at least one sample ahead of the row strobe.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_RONLY = 3'd1,
    CYC_READ  = 3'd2,
    CYC_WRITE = 3'd3,
    CYC_CBR   = 3'd4
  } cyc_kind_e;
endpackage

// File: rtl/dram_edge_sense.sv
module dram_edge_sense #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_n,
  output logic [W-1:0] fell
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= sig_n;
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_fall
      assign fell[g] = prev_q[g] & ~sig_n[g];
    end
  endgenerate
endmodule

// File: rtl/dram_timing_guard.sv
module dram_timing_guard #(
  parameter int T_RAS_MIN = 4,
  parameter int T_RP_MIN  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  output logic timing_err
);
  localparam int LW = $clog2(T_RAS_MIN + 1);
  localparam int HW = $clog2(T_RP_MIN + 1);
  localparam logic [LW-1:0] LMAX = LW'(T_RAS_MIN);
  localparam logic [HW-1:0] HMAX = HW'(T_RP_MIN);

  logic          ras_prev;
  logic [LW-1:0] low_cnt;
  logic [HW-1:0] high_cnt;
  logic          short_low, short_high;

  assign short_low  = !ras_prev && ras_n && (low_cnt < LMAX);
  assign short_high = ras_prev && !ras_n && (high_cnt < HMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_prev   <= 1'b1;
      low_cnt    <= '0;
      high_cnt   <= HMAX;
      timing_err <= 1'b0;
    end else begin
      ras_prev <= ras_n;
      if (ras_n) begin
        low_cnt  <= '0;
        high_cnt <= (high_cnt == HMAX) ? HMAX : high_cnt + 1'b1;
      end else begin
        high_cnt <= '0;
        low_cnt  <= (low_cnt == LMAX) ? LMAX : low_cnt + 1'b1;
      end
      if (short_low || short_high) timing_err <= 1'b1;
    end
  end
endmodule

// File: rtl/dram_byte_lane.sv
module dram_byte_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic access_ok,
  input  logic cas_n,
  input  logic cas_fell,
  input  logic we_n,
  input  logic we_fell,
  input  logic oe_n,
  output logic rd_now,
  output logic wr_now,
  output logic oe_q,
  output logic strobe_q
);
  assign rd_now = access_ok && !cas_n && !oe_n && we_n;
  assign wr_now = access_ok && !cas_n && !we_n && (cas_fell || we_fell);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q     <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      oe_q     <= rd_now;
      strobe_q <= wr_now;
    end
  end
endmodule

// File: rtl/dram_cycle_ctl.sv
module dram_cycle_ctl
  import dram_ctl_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int MR     = 3,
  parameter int MC     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_int_n,
  input  logic              ras_fell,
  input  logic              cas_fell,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_any,
  input  logic              wr_any,
  output logic              access_ok,
  output logic [MR-1:0]     row_lo,
  output logic [MC-1:0]     col_lo,
  output logic [2:0]        cyc_kind,
  output logic              rfsh_pulse,
  output logic [ADDR_W-1:0] rfsh_row
);
  logic              cyc_on;
  logic              is_cbr;
  logic [MC-1:0]     col_q;
  logic [ADDR_W-1:0] ref_cnt;
  cyc_kind_e         kind_q;

  assign access_ok = cyc_on && !is_cbr && !ras_n && !ras_fell;
  assign col_lo    = cas_fell ? addr[MC-1:0] : col_q;
  assign cyc_kind  = kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_on     <= 1'b0;
      is_cbr     <= 1'b0;
      row_lo     <= '0;
      col_q      <= '0;
      ref_cnt    <= '0;
      kind_q     <= CYC_IDLE;
      rfsh_pulse <= 1'b0;
      rfsh_row   <= '0;
    end else begin
      rfsh_pulse <= ras_fell;
      if (ras_fell) begin
        cyc_on <= 1'b1;
        is_cbr <= !cas_int_n;
        if (!cas_int_n) begin
          rfsh_row <= ref_cnt;
          ref_cnt  <= ref_cnt + 1'b1;
          kind_q   <= CYC_CBR;
        end else begin
          rfsh_row <= addr;
          row_lo   <= addr[MR-1:0];
          kind_q   <= CYC_RONLY;
        end
      end else begin
        if (ras_n && cas_int_n) cyc_on <= 1'b0;
        if (access_ok && cas_fell) col_q <= addr[MC-1:0];
        if (access_ok && wr_any)
          kind_q <= CYC_WRITE;
        else if (access_ok && rd_any && kind_q != CYC_WRITE)
          kind_q <= CYC_READ;
      end
    end
  end
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int MR     = 3,
  parameter int MC     = 3,
  parameter int DQ_W   = 16,
  parameter int LANE_W = 8
) (
  input  logic                   clk,
  input  logic [DQ_W/LANE_W-1:0] wr_en,
  input  logic [MR-1:0]          row,
  input  logic [MC-1:0]          col,
  input  logic [DQ_W-1:0]        wdata,
  output logic [DQ_W-1:0]        rdata
);
  localparam int LANES = DQ_W / LANE_W;
  localparam int DEPTH = 1 << (MR + MC);

  logic [DQ_W-1:0] mem [DEPTH];
  logic [MR+MC-1:0] idx;

  assign idx = {row, col};

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (wr_en[i]) mem[idx][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
    end
    rdata <= mem[idx];
  end
endmodule

// File: rtl/dram_dual_cas_ctl.sv
module dram_dual_cas_ctl #(
  parameter int ADDR_W       = 9,
  parameter int DQ_W         = 16,
  parameter int LANE_W       = 8,
  parameter int MEM_ROW_BITS = 3,
  parameter int MEM_COL_BITS = 3,
  parameter int T_RAS_MIN    = 4,
  parameter int T_RP_MIN     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              lcas_n,
  input  logic              ucas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic [1:0]        dq_oe,
  output logic [1:0]        wr_strobe,
  output logic [2:0]        cyc_kind,
  output logic              rfsh_pulse,
  output logic [ADDR_W-1:0] rfsh_row,
  output logic              timing_err
);
  localparam int LANES = DQ_W / LANE_W;

  logic [LANES-1:0]        lane_cas_n;
  logic                    cas_int_n;
  logic [4:0]              fell;
  logic                    access_ok;
  logic [LANES-1:0]        rd_now, wr_now, oe_q, strobe_q;
  logic [MEM_ROW_BITS-1:0] row_lo;
  logic [MEM_COL_BITS-1:0] col_lo;
  logic [DQ_W-1:0]         rdata;

  assign lane_cas_n = {ucas_n, lcas_n};
  assign cas_int_n  = &lane_cas_n;

  dram_edge_sense #(.W(5)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .sig_n({we_n, ucas_n, lcas_n, cas_int_n, ras_n}),
    .fell (fell)
  );

  dram_timing_guard #(.T_RAS_MIN(T_RAS_MIN), .T_RP_MIN(T_RP_MIN)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .timing_err(timing_err)
  );

  dram_cycle_ctl #(.ADDR_W(ADDR_W), .MR(MEM_ROW_BITS), .MC(MEM_COL_BITS)) u_cyc (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_int_n (cas_int_n),
    .ras_fell  (fell[0]),
    .cas_fell  (fell[1]),
    .addr      (addr),
    .rd_any    (|rd_now),
    .wr_any    (|wr_now),
    .access_ok (access_ok),
    .row_lo    (row_lo),
    .col_lo    (col_lo),
    .cyc_kind  (cyc_kind),
    .rfsh_pulse(rfsh_pulse),
    .rfsh_row  (rfsh_row)
  );

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      dram_byte_lane u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .access_ok(access_ok),
        .cas_n    (lane_cas_n[g]),
        .cas_fell (fell[2+g]),
        .we_n     (we_n),
        .we_fell  (fell[4]),
        .oe_n     (oe_n),
        .rd_now   (rd_now[g]),
        .wr_now   (wr_now[g]),
        .oe_q     (oe_q[g]),
        .strobe_q (strobe_q[g])
      );
      assign dq_out[g*LANE_W +: LANE_W] = oe_q[g] ? rdata[g*LANE_W +: LANE_W] : '0;
    end
  endgenerate

  dram_cell_array #(.MR(MEM_ROW_BITS), .MC(MEM_COL_BITS), .DQ_W(DQ_W), .LANE_W(LANE_W)) u_array (
    .clk  (clk),
    .wr_en(wr_now),
    .row  (row_lo),
    .col  (col_lo),
    .wdata(dq_in),
    .rdata(rdata)
  );

  assign dq_oe     = oe_q;
  assign wr_strobe = strobe_q;
endmodule

// File: rtl/dram_dual_cas_chk.sv
module dram_dual_cas_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ras_n,
  input logic        lcas_n,
  input logic        ucas_n,
  input logic        we_n,
  input logic        oe_n,
  input logic [15:0] dq_out,
  input logic [1:0]  dq_oe,
  input logic [1:0]  wr_strobe,
  input logic [2:0]  cyc_kind,
  input logic        rfsh_pulse,
  input logic        timing_err
);
  // R4
  lane0_read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[0] |-> $past(!lcas_n && !oe_n && we_n && !ras_n));

  // R4
  lane1_read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[1] |-> $past(!ucas_n && !oe_n && we_n && !ras_n));

  // R5
  lane0_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe[0] |-> $past(!lcas_n && !we_n));

  // R5
  lane1_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe[1] |-> $past(!ucas_n && !we_n));

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe[0] |=> !wr_strobe[0]);

  // R6
  idle_lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dq_oe[0] |-> dq_out[7:0] == 8'h00) and (!dq_oe[1] |-> dq_out[15:8] == 8'h00));

  // R7
  refresh_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 3'd4) |-> (dq_oe == 2'b00 && wr_strobe == 2'b00));

  // R2
  refresh_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_pulse |-> $past(!ras_n));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err |=> timing_err);
endmodule

bind dram_dual_cas_ctl dram_dual_cas_chk u_chk (.*);

// File: tb/dram_dual_cas_ctl_bench.sv
module dram_dual_cas_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [8:0]  addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe, wr_strobe;
  logic [2:0]  cyc_kind;
  logic        rfsh_pulse, timing_err;
  logic [8:0]  rfsh_row;

  int total = 0;
  int bad = 0;
  int ref_model = 0;

  always #2 clk = ~clk;

  dram_dual_cas_ctl u_dram_dual_cas_ctl (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .wr_strobe(wr_strobe), .cyc_kind(cyc_kind),
    .rfsh_pulse(rfsh_pulse), .rfsh_row(rfsh_row), .timing_err(timing_err)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic end_cycle();
    ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    tick(3);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_reset();
    check("R1 dq_oe", {30'd0, dq_oe}, 0);
    check("R1 wr_strobe", {30'd0, wr_strobe}, 0);
    check("R1 kind", {29'd0, cyc_kind}, 0);
    check("R1 err/pulse", {30'd0, timing_err, rfsh_pulse}, 0);
  endtask

  task automatic do_write(input logic [8:0] row, input logic [8:0] col,
                          input logic [15:0] data, input logic [1:0] lanes);
    addr = row; ras_n = 1'b0;
    tick(1);
    addr = col; we_n = 1'b0; dq_in = data;
    lcas_n = !lanes[0]; ucas_n = !lanes[1];
    tick(1);
    check("R5 write strobe", {30'd0, wr_strobe}, {30'd0, lanes});
    tick(1);
    check("R5 strobe one clock", {30'd0, wr_strobe}, 0);
    tick(1);
    check("R8 kind write", {29'd0, cyc_kind}, 3);
    end_cycle();
  endtask

  task automatic do_read(input logic [8:0] row, input logic [8:0] col,
                         input logic [1:0] lanes, input logic [15:0] exp, input string tag);
    oe_n = 1'b0; addr = row; ras_n = 1'b0;
    tick(1);
    addr = col; lcas_n = !lanes[0]; ucas_n = !lanes[1];
    tick(1);
    check({tag, " oe"}, {30'd0, dq_oe}, {30'd0, lanes});
    check({tag, " data"}, {16'd0, dq_out}, {16'd0, exp});
    tick(2);
    check("R8 kind read", {29'd0, cyc_kind}, 2);
    end_cycle();
  endtask

  task automatic t_basic();
    do_write(9'd1, 9'd2, 16'h1234, 2'b11);
    do_read(9'd1, 9'd2, 2'b11, 16'h1234, "R4 R10 read back");
    do_write(9'd3, 9'd3, 16'hBEEF, 2'b11);
    do_read(9'd3, 9'd3, 2'b10, 16'hBE00, "R6 upper only read");
  endtask

  task automatic t_lane_isolation();
    do_write(9'd3, 9'd3, 16'hAAAA, 2'b01);
    do_read(9'd3, 9'd3, 2'b11, 16'hBEAA, "R6 lower write kept upper");
    do_write(9'd3, 9'd3, 16'h5555, 2'b10);
    do_read(9'd3, 9'd3, 2'b11, 16'h55AA, "R6 upper write kept lower");
  endtask

  task automatic t_merge();
    do_write(9'd2, 9'd5, 16'hC3A5, 2'b11);
    do_write(9'd2, 9'd6, 16'h0F0F, 2'b11);
    oe_n = 1'b0; addr = 9'd2; ras_n = 1'b0;
    tick(1);
    addr = 9'd5; lcas_n = 1'b0;
    tick(1);
    check("R3 first lane oe", {30'd0, dq_oe}, 1);
    check("R3 first lane data", {16'd0, dq_out}, 32'h00A5);
    addr = 9'd6; ucas_n = 1'b0;
    tick(1);
    check("R3 late lane oe", {30'd0, dq_oe}, 3);
    check("R3 column kept", {16'd0, dq_out}, 32'hC3A5);
    lcas_n = 1'b1;
    tick(1);
    check("R6 lower released", {30'd0, dq_oe}, 2);
    check("R6 lower byte zero", {16'd0, dq_out}, 32'hC300);
    end_cycle();
    addr = 9'd2; ras_n = 1'b0;
    tick(1);
    addr = 9'd6; ucas_n = 1'b0; we_n = 1'b0; dq_in = 16'h7700;
    tick(1);
    addr = 9'd5; lcas_n = 1'b0; dq_in = 16'h0011;
    tick(1);
    check("R3 late lane write", {30'd0, wr_strobe}, 1);
    tick(1);
    end_cycle();
    do_read(9'd2, 9'd6, 2'b11, 16'h7711, "R3 late lane used first column");
  endtask

  task automatic t_late_strobes();
    addr = 9'd4; ras_n = 1'b0;
    tick(1);
    addr = 9'd1; lcas_n = 1'b0; ucas_n = 1'b0;
    tick(1);
    check("R5 no write while we high", {30'd0, wr_strobe}, 0);
    check("R4 no drive while oe high", {30'd0, dq_oe}, 0);
    we_n = 1'b0; dq_in = 16'h9A9A;
    tick(1);
    check("R5 we-late write", {30'd0, wr_strobe}, 3);
    tick(1);
    end_cycle();
    addr = 9'd4; ras_n = 1'b0;
    tick(1);
    addr = 9'd1; lcas_n = 1'b0; ucas_n = 1'b0;
    tick(1);
    check("R4 oe high no drive", {30'd0, dq_oe}, 0);
    oe_n = 1'b0;
    tick(1);
    check("R4 oe-late read oe", {30'd0, dq_oe}, 3);
    check("R4 oe-late read data", {16'd0, dq_out}, 32'h9A9A);
    tick(1);
    end_cycle();
  endtask

  task automatic t_ras_only();
    addr = 9'h1A5; ras_n = 1'b0;
    tick(1);
    check("R2 refresh pulse", {31'd0, rfsh_pulse}, 1);
    check("R2 refreshed row", {23'd0, rfsh_row}, 32'h1A5);
    check("R8 kind ras-only", {29'd0, cyc_kind}, 1);
    tick(1);
    check("R2 pulse one clock", {31'd0, rfsh_pulse}, 0);
    tick(2);
    end_cycle();
  endtask

  task automatic do_cbr(input logic [8:0] junk, input bit full);
    lcas_n = 1'b0; oe_n = 1'b0;
    tick(1);
    addr = junk; ras_n = 1'b0;
    tick(1);
    if (full || rfsh_row !== 9'(ref_model))
      check("R7 counter row", {23'd0, rfsh_row}, ref_model % 512);
    if (full) begin
      check("R7 pulse", {31'd0, rfsh_pulse}, 1);
      check("R8 kind cbr", {29'd0, cyc_kind}, 4);
    end
    tick(2);
    if (full) check("R7 no data", {28'd0, dq_oe, wr_strobe}, 0);
    tick(1);
    ras_n = 1'b1;
    tick(1);
    end_cycle();
    ref_model = (ref_model + 1) % 512;
  endtask

  task automatic t_cbr();
    do_cbr(9'h155, 1'b1);
    do_cbr(9'h0AA, 1'b1);
    do_read(9'd1, 9'd2, 2'b11, 16'h1234, "R7 data untouched");
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 520; k++) do_cbr(9'(k), 1'b0);
    do_cbr(9'h1FF, 1'b1);
  endtask

  task automatic t_timing();
    check("R9 clean so far", {31'd0, timing_err}, 0);
    addr = 9'd7; ras_n = 1'b0;
    tick(2);
    ras_n = 1'b1;
    tick(1);
    check("R9 short ras low", {31'd0, timing_err}, 1);
    tick(5);
    check("R9 sticky", {31'd0, timing_err}, 1);
    do_reset();
    check("R1 err cleared", {31'd0, timing_err}, 0);
    ref_model = 0;
    addr = 9'd7; ras_n = 1'b0;
    tick(4);
    ras_n = 1'b1;
    tick(1);
    check("R9 legal ras low", {31'd0, timing_err}, 0);
    ras_n = 1'b0;
    tick(1);
    check("R9 short precharge", {31'd0, timing_err}, 1);
    tick(4);
    end_cycle();
    do_reset();
    do_cbr(9'h123, 1'b1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_basic();
    t_lane_isolation();
    t_merge();
    t_late_strobes();
    t_ras_only();
    t_cbr();
    t_wrap();
    t_timing();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule